// File: doc/BRIEF.md
# Sliding-Window Activity Threshold Detector

This block watches a one-bit motion signal and reports whether activity has been dense in the recent past. It takes one sample of the input on every rising clock edge and stores it in a circular history of `WINDOW_LEN` entries. A write pointer walks through the history and wraps, so each new sample replaces the oldest one. The history therefore always holds the most recent `WINDOW_LEN` samples.

The block does not add up the whole history every cycle. It keeps a running population count instead. Each cycle the count gains the incoming sample and loses the sample being overwritten. A registered comparator raises the flag while that count is strictly above `THRESHOLD`. The defaults are a 100-sample window and a threshold of 10.

The history is held without a reset, so it can sit in a small RAM. A separate "filled" bit masks entries that have not been written since reset, which makes the window count as empty after reset. The flag can drive any downstream action. Filtering of the input is left to the surrounding logic.

Top module: `activity_window_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the flag clears and the window is emptied. After `rst` falls, only samples captured after the release are counted, and the flag stays low until more than `THRESHOLD` of them are 1.
- R2: Every rising edge with `rst` low captures exactly one sample of `motion_in` into the window: 1 when the input is high, 0 when it is low.
- R3: The comparison is strict. A window holding exactly `THRESHOLD` ones keeps the flag low, and `THRESHOLD`+1 ones raise it.
- R4: `active_flag` is registered. After edge n it shows the comparison for the window as it stood after edge n-1, so a sample affects the flag two edges after it is presented.
- R5: Only the last `WINDOW_LEN` captured samples are counted. A 1 stops counting once `WINDOW_LEN` newer samples have been captured.
- R6: The internal count never exceeds `WINDOW_LEN`, and it changes by at most one per edge. A window that is all ones keeps the flag high.
- R7: The write position runs from 0 to `WINDOW_LEN`-1 and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| motion_in | input | 1 | Motion sample, captured every edge |
| active_flag | output | 1 | High while the count of ones in the window exceeds the threshold (registered) |

## Verification
The bench instantiates the block with its defaults: a 100-sample window and a threshold of 10. These values allow the exact 10-versus-11 boundary to be tested with directed bursts. They also keep the window short enough that ones age out and the write pointer wraps many times within a run. Random stretches at low, near-threshold and high densities make the flag toggle often. An all-ones stretch drives the count to its ceiling of 100, and a mid-run reset tests that the window refills from empty.

// File: rtl/actwin_pkg.sv
package actwin_pkg;

  // Bits needed to hold any value from 0 to n inclusive.
  function automatic int unsigned count_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Bits needed to address n entries.
  function automatic int unsigned index_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Encoding of the running count update.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_DEC  = 2'b01,
    STEP_INC  = 2'b10,
    STEP_SWAP = 2'b11
  } count_step_e;

endpackage

// File: rtl/actwin_history.sv
module actwin_history #(
  parameter int unsigned WINDOW_LEN = 100,
  parameter int unsigned IW         = actwin_pkg::index_bits(WINDOW_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_in,
  output logic          evict_bit,
  output logic [IW-1:0] wr_idx
);

  localparam logic [IW-1:0] LAST_IDX = IW'(WINDOW_LEN - 1);

  // History storage: no reset, so it may map onto a small RAM.
  logic hist_mem [0:WINDOW_LEN-1];
  logic filled_q;
  logic at_last;

  assign at_last = (wr_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx   <= '0;
      filled_q <= 1'b0;
    end else begin
      wr_idx <= at_last ? '0 : wr_idx + IW'(1);
      if (at_last) filled_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) hist_mem[wr_idx] <= sample_in;
  end

  // Until the first wrap, the slot being overwritten was never written
  // since reset and counts as zero.
  assign evict_bit = filled_q & hist_mem[wr_idx];

endmodule

// File: rtl/actwin_counter.sv
module actwin_counter #(
  parameter int unsigned WINDOW_LEN = 100,
  parameter int unsigned CW         = actwin_pkg::count_bits(WINDOW_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          add_bit,
  input  logic          sub_bit,
  output logic [CW-1:0] count
);
  import actwin_pkg::*;

  count_step_e step;
  assign step = count_step_e'({add_bit, sub_bit});

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      unique case (step)
        STEP_INC: count <= count + CW'(1);
        STEP_DEC: count <= count - CW'(1);
        default:  count <= count;
      endcase
    end
  end

endmodule

// File: rtl/actwin_threshold.sv
module actwin_threshold #(
  parameter int unsigned CW        = 7,
  parameter int unsigned THRESHOLD = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  output logic          flag_q
);

  logic above;
  assign above = (32'(count) > THRESHOLD);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= above;
  end

endmodule

// File: rtl/activity_window_detector.sv
module activity_window_detector #(
  parameter int unsigned WINDOW_LEN = 100,
  parameter int unsigned THRESHOLD  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic motion_in,
  output logic active_flag
);

  localparam int unsigned IW = actwin_pkg::index_bits(WINDOW_LEN);
  localparam int unsigned CW = actwin_pkg::count_bits(WINDOW_LEN);

  logic          evict_bit;
  logic [IW-1:0] wr_idx;
  logic [CW-1:0] win_count;

  actwin_history #(.WINDOW_LEN(WINDOW_LEN), .IW(IW)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .sample_in (motion_in),
    .evict_bit (evict_bit),
    .wr_idx    (wr_idx)
  );

  actwin_counter #(.WINDOW_LEN(WINDOW_LEN), .CW(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .add_bit (motion_in),
    .sub_bit (evict_bit),
    .count   (win_count)
  );

  actwin_threshold #(.CW(CW), .THRESHOLD(THRESHOLD)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .count  (win_count),
    .flag_q (active_flag)
  );

endmodule

// File: rtl/actwin_checker.sv
module actwin_checker #(
  parameter int unsigned WINDOW_LEN = 100,
  parameter int unsigned THRESHOLD  = 10,
  parameter int unsigned IW         = 7,
  parameter int unsigned CW         = 7
) (
  input logic          clk,
  input logic          rst,
  input logic [IW-1:0] wr_idx,
  input logic [CW-1:0] win_count,
  input logic          active_flag
);

  // R7: pointer stays inside the window
  assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
    32'(wr_idx) < WINDOW_LEN);

  // R7: pointer returns to zero after the last slot
  assert_idx_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (32'(wr_idx) == WINDOW_LEN - 1) |=> (wr_idx == '0));

  // R6: count bounded by the window length
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    32'(win_count) <= WINDOW_LEN);

  // R6: count moves by at most one per edge
  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (32'(win_count) == 32'($past(win_count)) ||
              32'(win_count) == 32'($past(win_count)) + 1 ||
              32'(win_count) + 1 == 32'($past(win_count))));

  // R3/R4: a rising flag follows a count above threshold one edge earlier
  assert_flag_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(active_flag) |-> (32'($past(win_count)) > THRESHOLD));

  // R3: a count at or below threshold keeps the flag low next edge
  assert_flag_low_R3: assert property (@(posedge clk) disable iff (rst)
    (32'(win_count) <= THRESHOLD) |=> !active_flag);

endmodule

bind activity_window_detector actwin_checker #(
  .WINDOW_LEN (WINDOW_LEN),
  .THRESHOLD  (THRESHOLD),
  .IW         (IW),
  .CW         (CW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_idx      (wr_idx),
  .win_count   (win_count),
  .active_flag (active_flag)
);

// File: tb/sim_activity_window_detector.sv
`timescale 1ns/1ps
module sim_activity_window_detector;

  localparam int W  = 100;
  localparam int TH = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic motion_in = 1'b0;
  logic active_flag;

  int checks = 0;
  int errors = 0;
  bit samples[$];

  always #5 clk = ~clk;

  activity_window_detector #(.WINDOW_LEN(W), .THRESHOLD(TH)) u0 (
    .clk         (clk),
    .rst         (rst),
    .motion_in   (motion_in),
    .active_flag (active_flag)
  );

  // Ones among the last W samples of the first m captured.
  function automatic int ones_in_window(int m);
    int s = 0;
    int lo = (m > W) ? m - W : 0;
    for (int i = lo; i < m; i++) s += samples[i];
    return s;
  endfunction

  // Flag after the latest edge reflects the window one edge earlier.
  function automatic bit expected_flag();
    int m = samples.size() - 1;
    if (m < 1) return 1'b0;
    return ones_in_window(m) > TH;
  endfunction

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: active_flag=%0b expected=%0b at sample %0d",
               tag, act, exp, samples.size());
    end
  endtask

  // Present v, let one edge capture it, check at the following negedge.
  task automatic step(bit v, string tag);
    motion_in = v;
    @(posedge clk);
    samples.push_back(v);
    @(negedge clk);
    check(active_flag, expected_flag(), tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    motion_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(active_flag, 1'b0, "R1 flag during reset");
    samples.delete();
    rst = 1'b0;
  endtask

  task automatic random_run(int n, int pct, string tag);
    for (int i = 0; i < n; i++) step(($urandom % 100) < pct, tag);
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240517));
    @(negedge clk);
    do_reset();

    // R1: first samples after release are all ones but stay below threshold
    for (int i = 0; i < TH; i++) step(1'b1, "R1 R2 fill");
    for (int i = 0; i < 20; i++) step(1'b0, "R3 exactly threshold");
    check(active_flag, 1'b0, "R3 ten ones keep flag low");

    // R3/R4: eleventh one; flag rises only one edge after the count does
    step(1'b1, "R2 eleventh one captured");
    check(active_flag, 1'b0, "R4 flag not yet high");
    step(1'b0, "R4 flag one edge later");
    check(active_flag, 1'b1, "R3 R4 flag high at eleven");

    // R5/R7: ones age out once W newer samples pass; pointer wraps
    for (int i = 0; i < W + 5; i++) step(1'b0, "R5 R7 ageing out");
    check(active_flag, 1'b0, "R5 flag low after ones leave window");

    // R6: saturated window keeps flag high, count ceiling W
    for (int i = 0; i < W + 20; i++) step(1'b1, "R6 all ones");
    check(active_flag, 1'b1, "R6 full window flag high");

    // Random densities around and away from the threshold
    random_run(400, 5,  "R5 sparse random");
    random_run(600, 11, "R3 near threshold random");
    random_run(300, 50, "R2 dense random");

    // R1: mid-run reset then refill from empty
    do_reset();
    for (int i = 0; i < TH; i++) step(1'b1, "R1 refill after reset");
    check(active_flag, 1'b0, "R1 window empty after reset");
    random_run(400, 12, "R7 post reset random");

    finish_run();
  end

endmodule